// File: doc/BRIEF.md
# Shared-Adder Add/Subtract Unit with Carry

This block is an 8-bit arithmetic unit with a registered result. It handles both add-with-carry and subtract-with-carry on one ripple adder. For a subtract, the operand is inverted before it enters the adder, so the adder computes `acc + ~opnd + cin`. A pulse on `valid_i` captures the result and the four flags: carry, zero, negative and signed overflow. They hold until the next pulse.

To build a wider operation, the caller works through the bytes from low to high and feeds `carry_o` back into `carry_i` for each byte. The parameter `CARRY_MODE` sets what the carry flag means during a subtract:

- **`CARRY_NO_BORROW` (default):** a set carry means "no borrow". The adder carry passes straight through.
- **`CARRY_BORROW`:** the carry flag is the borrow itself. The carry is inverted on the way into the adder and again on the way out. A cleared carry then starts both add chains and subtract chains.

Top module: `addsub_unit`

## Requirements
- R1: While `rst_ni` is low, and on the first clock edge after reset, `result_o`, `carry_o`, `zero_o`, `neg_o` and `ovf_o` are all 0.
- R2: With `valid_i`=1 and `op_sub_i`=0, after the next rising edge `result_o` = (acc + opnd + carry_i) mod 256 and `carry_o` = bit 8 of that sum. This holds in both modes.
- R3: In `CARRY_NO_BORROW` mode with `op_sub_i`=1:
  - `result_o` = (acc + ~opnd + carry_i) mod 256, which is acc − opnd − 1 when `carry_i`=0.
  - `carry_o` is 1 exactly when no borrow occurred.
- R4: In `CARRY_BORROW` mode with `op_sub_i`=1:
  - `result_o` = (acc − opnd − carry_i) mod 256.
  - `carry_o` is 1 exactly when a borrow occurred, that is, when acc < opnd + carry_i.
- R5: `zero_o` is 1 exactly when the stored 8-bit result is 0.
- R6: `neg_o` equals bit 7 of the stored result.
- R7: `ovf_o` is set when both adder inputs have the same sign and the result sign differs. The adder inputs are acc and either opnd or ~opnd. This equals two's-complement overflow of the signed operation.
- R8: While `valid_i` is 0, all outputs keep their values whatever the other inputs do.
- R9: Chaining bytes low to high with `carry_o` fed back as `carry_i` gives the correct multi-byte sum or difference. The starting carry is:
  - 0 for add in both modes;
  - 1 for subtract in `CARRY_NO_BORROW` mode;
  - 0 for subtract in `CARRY_BORROW` mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Capture strobe for result and flags |
| op_sub_i | input | 1 | 0 = add with carry, 1 = subtract with carry |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Memory operand |
| carry_i | input | 1 | Carry flag in, meaning set by `CARRY_MODE` |
| result_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry flag |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |
| ovf_o | output | 1 | Registered signed overflow flag |

## Verification
The bench runs both carry modes side by side, each instance with its own carry input, and mixes seeded random traffic with directed cases. The directed cases target the following:

- **Wrong carry polarity on a subtract:** a design that gets this wrong is off by one whenever a borrow starts a chain. It also reports a borrow where there was none.
- **Wrapping overflow edges (0x7F+1, 0x80−1, 0−0 with borrow):** a wrong overflow rule flags 0x80−1 wrongly or misses 0x7F+1.
- **16-bit chains:** a carry that is not propagated, or not inverted on output in borrow mode, corrupts the high byte.
- **Idle cycles with changing inputs:** these expose a register that captures without the strobe.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    typedef enum logic {
        CARRY_NO_BORROW = 1'b0,
        CARRY_BORROW    = 1'b1
    } carry_mode_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } addsub_op_e;

endpackage

// File: rtl/addsub_operand_prep.sv
module addsub_operand_prep
    import addsub_pkg::*;
#(
    parameter int          WIDTH      = 8,
    parameter carry_mode_e CARRY_MODE = CARRY_NO_BORROW
) (
    input  addsub_op_e       op_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] b_o,
    output logic             cin_o
);

    logic flip_carry;

    generate
        if (CARRY_MODE == CARRY_BORROW) begin : g_borrow
            assign flip_carry = (op_i == OP_SUB);
        end else begin : g_noborrow
            assign flip_carry = 1'b0;
        end
    endgenerate

    always_comb begin
        b_o   = (op_i == OP_SUB) ? ~opnd_i : opnd_i;
        cin_o = carry_i ^ flip_carry;
    end

endmodule

// File: rtl/addsub_ripple.sv
module addsub_ripple #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]   = a_i[i] ^ b_i[i] ^ chain[i];
            assign chain[i+1] = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
        end
    endgenerate

    assign cout_o = chain[WIDTH];

endmodule

// File: rtl/addsub_flags.sv
module addsub_flags #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] sum_i,
    output logic             zero_o,
    output logic             neg_o,
    output logic             ovf_o
);

    localparam int MSB = WIDTH - 1;

    always_comb begin
        zero_o = (sum_i == '0);
        neg_o  = sum_i[MSB];
        ovf_o  = (a_i[MSB] == b_i[MSB]) && (sum_i[MSB] != a_i[MSB]);
    end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int          WIDTH      = 8,
    parameter carry_mode_e CARRY_MODE = CARRY_NO_BORROW
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             valid_i,
    input  logic             op_sub_i,
    input  logic [WIDTH-1:0] acc_i,
    input  logic [WIDTH-1:0] opnd_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             zero_o,
    output logic             neg_o,
    output logic             ovf_o
);

    localparam int  MSB       = WIDTH - 1;
    localparam logic INV_MODE = (CARRY_MODE == CARRY_BORROW);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             c;
        logic             z;
        logic             n;
        logic             v;
    } alu_state_t;

    alu_state_t state_d, state_q;

    addsub_op_e       op;
    logic [WIDTH-1:0] b_in;
    logic             cin;
    logic [WIDTH-1:0] sum;
    logic             cout;
    logic             z_f, n_f, v_f;

    assign op = addsub_op_e'(op_sub_i);

    addsub_operand_prep #(.WIDTH(WIDTH), .CARRY_MODE(CARRY_MODE)) u_prep (
        .op_i   (op),
        .opnd_i (opnd_i),
        .carry_i(carry_i),
        .b_o    (b_in),
        .cin_o  (cin)
    );

    addsub_ripple #(.WIDTH(WIDTH)) u_adder (
        .a_i   (acc_i),
        .b_i   (b_in),
        .cin_i (cin),
        .sum_o (sum),
        .cout_o(cout)
    );

    addsub_flags #(.WIDTH(WIDTH)) u_flags (
        .a_i   (acc_i),
        .b_i   (b_in),
        .sum_i (sum),
        .zero_o(z_f),
        .neg_o (n_f),
        .ovf_o (v_f)
    );

    always_comb begin
        state_d = state_q;
        if (valid_i) begin
            state_d.res = sum;
            state_d.c   = (INV_MODE && (op == OP_SUB)) ? ~cout : cout;
            state_d.z   = z_f;
            state_d.n   = n_f;
            state_d.v   = v_f;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.res;
    assign carry_o  = state_q.c;
    assign zero_o   = state_q.z;
    assign neg_o    = state_q.n;
    assign ovf_o    = state_q.v;

    // Borrow amount seen by a subtract, per mode, computed independently of the adder
    logic brw_in;
    assign brw_in = INV_MODE ? carry_i : ~carry_i;

    assert_add_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !op_sub_i) |=> {carry_o, result_o} ==
            $past({1'b0, acc_i} + {1'b0, opnd_i} + {{WIDTH{1'b0}}, carry_i}));

    // R3 / R4: difference value in either mode
    assert_sub_R3_R4_val: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && op_sub_i) |=> result_o ==
            $past(acc_i - opnd_i - {{(WIDTH-1){1'b0}}, brw_in}));

    assert_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> zero_o == (result_o == '0));

    assert_neg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i |=> neg_o == result_o[MSB]);

    assert_ovf_sign_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !op_sub_i && (acc_i[MSB] != opnd_i[MSB])) |=> !ovf_o);

    assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> $stable(result_o) && $stable(carry_o) && $stable(zero_o)
                     && $stable(neg_o) && $stable(ovf_o));

endmodule

// File: tb/addsub_unit_bench.sv
`timescale 1ns/1ps
module addsub_unit_bench;
    import addsub_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid = 1'b0;
    logic       sub = 1'b0;
    logic [7:0] acc = '0;
    logic [7:0] opnd = '0;
    logic       c0 = 1'b0;
    logic       c1 = 1'b0;

    logic [7:0] r0, r1;
    logic       co0, co1, z0, z1, n0, n1, v0, v1;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    addsub_unit #(.WIDTH(8), .CARRY_MODE(CARRY_NO_BORROW)) u_addsub_unit (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_sub_i(sub),
        .acc_i(acc), .opnd_i(opnd), .carry_i(c0),
        .result_o(r0), .carry_o(co0), .zero_o(z0), .neg_o(n0), .ovf_o(v0));

    addsub_unit #(.WIDTH(8), .CARRY_MODE(CARRY_BORROW)) u_addsub_unit_brw (
        .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_sub_i(sub),
        .acc_i(acc), .opnd_i(opnd), .carry_i(c1),
        .result_o(r1), .carry_o(co1), .zero_o(z1), .neg_o(n1), .ovf_o(v1));

    // Model: returns {result[7:0], carry, zero, neg, ovf}
    function automatic logic [11:0] model(input logic [7:0] a, input logic [7:0] m,
                                          input logic c, input logic s, input logic brw_mode);
        int ua, um, sa, sm, ur, sr, bw;
        logic cf;
        logic [7:0] res;
        ua = int'(a);
        um = int'(m);
        sa = int'($signed(a));
        sm = int'($signed(m));
        if (!s) begin
            ur = ua + um + int'(c);
            sr = sa + sm + int'(c);
            cf = (ur > 255);
        end else begin
            bw = brw_mode ? int'(c) : int'(!c);
            ur = ua - um - bw;
            sr = sa - sm - bw;
            cf = brw_mode ? (ur < 0) : (ur >= 0);
        end
        res = 8'(ur);
        return {res, cf, (res == 8'h00), res[7], (sr > 127 || sr < -128)};
    endfunction

    task automatic check(input string req, input string what, input logic [11:0] act,
                         input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic s, input logic brw_mode);
        if (!s) return "R2";
        return brw_mode ? "R4" : "R3";
    endfunction

    // Apply one operation to both instances and check after capture edge
    task automatic run_op(input logic [7:0] a, input logic [7:0] m, input logic s,
                          input logic ca, input logic cb);
        @(negedge clk);
        acc = a; opnd = m; sub = s; c0 = ca; c1 = cb; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        check(req_of(s, 1'b0), "nb-mode R5 R6 R7", {r0, co0, z0, n0, v0}, model(a, m, ca, s, 1'b0));
        check(req_of(s, 1'b1), "b-mode R5 R6 R7",  {r1, co1, z1, n1, v1}, model(a, m, cb, s, 1'b1));
    endtask

    // 16-bit chain in both modes (R9)
    task automatic chain16(input logic [15:0] x, input logic [15:0] y, input logic s);
        logic [15:0] g0, g1, e;
        logic ca, cb;
        ca = s ? 1'b1 : 1'b0;
        cb = 1'b0;
        @(negedge clk);
        acc = x[7:0]; opnd = y[7:0]; sub = s; c0 = ca; c1 = cb; valid = 1'b1;
        @(negedge clk);
        g0[7:0] = r0; g1[7:0] = r1;
        acc = x[15:8]; opnd = y[15:8]; c0 = co0; c1 = co1; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        g0[15:8] = r0; g1[15:8] = r1;
        e = s ? (x - y) : (x + y);
        check("R9", "chain nb-mode", {g0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00}[27:16], {e, 4'h0}[19:8]);
        check("R9", "chain nb-mode full", {4'h0, g0}, {4'h0, e});
        check("R9", "chain b-mode full",  {4'h0, g1}, {4'h0, e});
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [11:0] held0, held1;
        void'($urandom(32'h5EED_0A11));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset nb", {r0, co0, z0, n0, v0}, 12'h000);
        check("R1", "reset b",  {r1, co1, z1, n1, v1}, 12'h000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "after reset", {r0, co0, z0, n0, v0, r1[3:0]}[11:0], 12'h000);

        // Directed corners
        run_op(8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);   // R7 positive overflow
        run_op(8'hFF, 8'h01, 1'b0, 1'b0, 1'b0);   // R2 carry out, R5 zero
        run_op(8'h80, 8'h01, 1'b1, 1'b1, 1'b0);   // R7 negative overflow on subtract
        run_op(8'h00, 8'h00, 1'b1, 1'b0, 1'b1);   // R3/R4 borrow in gives 0xFF
        run_op(8'h00, 8'h00, 1'b1, 1'b1, 1'b0);   // R5 zero with no borrow
        run_op(8'h05, 8'h05, 1'b1, 1'b0, 1'b1);   // a-m-1 with borrow
        run_op(8'h80, 8'h80, 1'b0, 1'b1, 1'b1);   // R7 and carry
        run_op(8'h10, 8'h20, 1'b1, 1'b1, 1'b0);   // R6 negative result

        // R8: idle cycles with changing inputs must not disturb outputs
        held0 = {r0, co0, z0, n0, v0};
        held1 = {r1, co1, z1, n1, v1};
        acc = 8'hAA; opnd = 8'h55; sub = 1'b0; c0 = 1'b1; c1 = 1'b1;
        @(negedge clk);
        acc = 8'h01; sub = 1'b1;
        @(negedge clk);
        check("R8", "hold nb", {r0, co0, z0, n0, v0}, held0);
        check("R8", "hold b",  {r1, co1, z1, n1, v1}, held1);

        // R9 chains
        chain16(16'h12FF, 16'h0001, 1'b0);
        chain16(16'h0100, 16'h0001, 1'b1);
        chain16(16'h0000, 16'h0001, 1'b1);
        chain16(16'h8000, 16'hFFFF, 1'b1);

        // Constrained random traffic
        for (int k = 0; k < 400; k++) begin
            logic [7:0] ra, rm;
            logic rs, rc0, rc1;
            ra  = 8'($urandom());
            rm  = ((k % 5) == 0) ? ra : 8'($urandom());
            rs  = 1'($urandom());
            rc0 = 1'($urandom());
            rc1 = 1'($urandom());
            run_op(ra, rm, rs, rc0, rc1);
        end
        for (int k = 0; k < 40; k++) begin
            chain16(16'($urandom()), 16'($urandom()), 1'($urandom()));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule